// File: doc/BRIEF.md
# Column-Associative Cache Controller

This block is a read-allocate cache controller that keeps one word per line in a single direct-mapped array. It behaves like a two-way cache by checking two lines one after the other. The home line is picked by the low bits of the word address. The alternate line uses the same index with its top bit inverted. A first-probe hit answers in one cycle. A hit on the second probe answers in two cycles and exchanges the two lines, so the requested word moves to its home slot.

Each line carries a valid bit and an "alternate placement" bit. The alternate placement bit marks a block that lives in its alternate slot. If the home line misses and holds such a block, the requested word cannot be in the alternate slot. The controller then skips the second probe and goes straight to the memory fetch. On a miss after both probes, the old home block is pushed into the alternate slot with its alternate placement bit set, and the word that was in the alternate slot is dropped. The fetched word goes into the home slot with its alternate placement bit cleared.

The CPU side offers a request strobe with an address, plus a ready flag, a one-cycle done pulse, a hit flag and the read data. The memory side uses a request/valid handshake for a single word.

Top module: `ca_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1, and `cpu_done` and `mem_req` are 0. The first access to any address is a miss.
- R2: The home index is address bits [IDX_W-1:0]. When the home line is valid and holds the address, `cpu_done` and `cpu_hit` are 1 in the cycle after acceptance, with the stored word on `cpu_rdata`.
- R3: The alternate index is the home index with bit IDX_W-1 inverted. When the home probe misses and the alternate line holds the address, `cpu_done` and `cpu_hit` are 1 two cycles after acceptance.
- R4: A second-probe hit exchanges the two lines. A repeat of the same address is then a first-probe hit. The block that was displaced is found by its own second probe.
- R5: A miss after both probes raises `mem_req` two cycles after acceptance.
- R6: When the home line is valid, has its alternate placement bit set and does not hold the address, the second probe is skipped and `mem_req` rises in the cycle after acceptance.
- R7: On a miss after both probes, the old home block moves to the alternate slot and is then reached by a second probe. The fetched word sits in the home slot, and the old alternate-slot block is discarded, so it misses next time.
- R8: An early-miss fill overwrites only the home slot and leaves the alternate slot unchanged.
- R9: `mem_req` stays high with a stable `mem_addr` equal to the request address until `mem_valid`. In the cycle after `mem_valid`, `cpu_done` is 1, `cpu_hit` is 0 and `cpu_rdata` equals the returned word.
- R10: `cpu_ready` is 0 from acceptance until the response cycle. A `cpu_req` seen while `cpu_ready` is 0 is ignored.
- R11: An invalid line never hits. An invalid home line never causes an early miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Read strobe, taken when `cpu_ready` is 1 |
| cpu_addr | input | ADDR_W | Word address of the read |
| cpu_ready | output | 1 | Controller idle and able to accept |
| cpu_done | output | 1 | One-cycle response pulse |
| cpu_hit | output | 1 | Response was served from the array |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| mem_req | output | 1 | Fetch request to lower memory |
| mem_addr | output | ADDR_W | Fetch address |
| mem_valid | input | 1 | Fetch data valid |
| mem_rdata | input | DATA_W | Fetched word |

## Verification
The assertions assume the memory side raises `mem_valid` only while `mem_req` is high, and keeps it for exactly one sampled edge per fetch. The bench's responder gives this by driving `mem_valid` only against a pending request, after a random delay of zero to three cycles, and by dropping it once the request falls. The latency properties also assume `cpu_req` is meaningful only while `cpu_ready` is 1. The bench drives a stray request only during busy cycles, to show that it is ignored, and uses a small address pool so that hits, swaps, early misses and evictions all occur often.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic [1:0] {
    CA_IDLE = 2'd0,
    CA_ALT  = 2'd1,
    CA_FILL = 2'd2
  } ca_phase_e;
endpackage

// File: rtl/ca_line_store.sv
module ca_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic              rd_a_valid,
  output logic              rd_a_rehash,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic              rd_b_valid,
  output logic [TAG_W-1:0]  rd_b_tag,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_a_en,
  input  logic [IDX_W-1:0]  wr_a_idx,
  input  logic              wr_a_valid,
  input  logic              wr_a_rehash,
  input  logic [TAG_W-1:0]  wr_a_tag,
  input  logic [DATA_W-1:0] wr_a_data,
  input  logic              wr_b_en,
  input  logic [IDX_W-1:0]  wr_b_idx,
  input  logic              wr_b_valid,
  input  logic              wr_b_rehash,
  input  logic [TAG_W-1:0]  wr_b_tag,
  input  logic [DATA_W-1:0] wr_b_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  rehash_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      rehash_q <= '0;
    end else begin
      if (wr_a_en) begin
        valid_q[wr_a_idx]  <= wr_a_valid;
        rehash_q[wr_a_idx] <= wr_a_rehash;
      end
      if (wr_b_en) begin
        valid_q[wr_b_idx]  <= wr_b_valid;
        rehash_q[wr_b_idx] <= wr_b_rehash;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_a_en) begin
      tag_q[wr_a_idx]  <= wr_a_tag;
      data_q[wr_a_idx] <= wr_a_data;
    end
    if (wr_b_en) begin
      tag_q[wr_b_idx]  <= wr_b_tag;
      data_q[wr_b_idx] <= wr_b_data;
    end
  end

  assign rd_a_valid  = valid_q[rd_a_idx];
  assign rd_a_rehash = rehash_q[rd_a_idx];
  assign rd_a_tag    = tag_q[rd_a_idx];
  assign rd_a_data   = data_q[rd_a_idx];
  assign rd_b_valid  = valid_q[rd_b_idx];
  assign rd_b_tag    = tag_q[rd_b_idx];
  assign rd_b_data   = data_q[rd_b_idx];

  // R7: a swap or a fill touches two distinct lines
  a_r7_ports_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_en && wr_b_en) |-> (wr_a_idx != wr_b_idx));
endmodule

// File: rtl/ca_probe.sv
module ca_probe #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = ADDR_W - IDX_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              home_valid,
  input  logic              home_rehash,
  input  logic [TAG_W-1:0]  home_tag,
  input  logic              alt_valid,
  input  logic [TAG_W-1:0]  alt_tag,
  output logic [IDX_W-1:0]  idx_home,
  output logic [IDX_W-1:0]  idx_alt,
  output logic [TAG_W-1:0]  tag_key,
  output logic              hit_home,
  output logic              hit_alt,
  output logic              early_miss
);
  function automatic logic [IDX_W-1:0] home_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] alt_index(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] flip;
    flip = '0;
    flip[IDX_W-1] = 1'b1;
    return a[IDX_W-1:0] ^ flip;
  endfunction

  // key keeps the index top bit so a rehashed block stays distinguishable
  function automatic logic [TAG_W-1:0] key_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W-1];
  endfunction

  assign idx_home   = home_index(addr);
  assign idx_alt    = alt_index(addr);
  assign tag_key    = key_of(addr);
  assign hit_home   = home_valid && (home_tag == tag_key);
  assign hit_alt    = alt_valid && (alt_tag == tag_key);
  assign early_miss = !hit_home && home_valid && home_rehash;
endmodule

// File: rtl/ca_ctrl.sv
module ca_ctrl
  import ca_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = ADDR_W - IDX_W + 1,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic [IDX_W-1:0]  idx_home,
  input  logic [IDX_W-1:0]  idx_alt,
  input  logic [TAG_W-1:0]  tag_key,
  input  logic              hit_home,
  input  logic              hit_alt,
  input  logic              early_miss,
  input  logic              home_valid,
  input  logic [TAG_W-1:0]  home_tag,
  input  logic [DATA_W-1:0] home_data,
  input  logic [TAG_W-1:0]  alt_tag,
  input  logic [DATA_W-1:0] alt_data,
  output logic              wr_a_en,
  output logic [IDX_W-1:0]  wr_a_idx,
  output logic              wr_a_valid,
  output logic              wr_a_rehash,
  output logic [TAG_W-1:0]  wr_a_tag,
  output logic [DATA_W-1:0] wr_a_data,
  output logic              wr_b_en,
  output logic [IDX_W-1:0]  wr_b_idx,
  output logic              wr_b_valid,
  output logic              wr_b_rehash,
  output logic [TAG_W-1:0]  wr_b_tag,
  output logic [DATA_W-1:0] wr_b_data,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata
);
  ca_phase_e         phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              early_q, early_d;
  logic              done_d, hit_d;
  logic [DATA_W-1:0] rdata_d;

  assign probe_addr = (phase_q == CA_IDLE) ? cpu_addr : addr_q;
  assign cpu_ready  = (phase_q == CA_IDLE);
  assign mem_req    = (phase_q == CA_FILL);
  assign mem_addr   = addr_q;

  always_comb begin
    phase_d     = phase_q;
    addr_d      = addr_q;
    early_d     = early_q;
    done_d      = 1'b0;
    hit_d       = 1'b0;
    rdata_d     = cpu_rdata;
    wr_a_en     = 1'b0;
    wr_a_idx    = idx_home;
    wr_a_valid  = 1'b1;
    wr_a_rehash = 1'b0;
    wr_a_tag    = tag_key;
    wr_a_data   = mem_rdata;
    wr_b_en     = 1'b0;
    wr_b_idx    = idx_alt;
    wr_b_valid  = home_valid;
    wr_b_rehash = 1'b1;
    wr_b_tag    = home_tag;
    wr_b_data   = home_data;
    unique case (phase_q)
      CA_IDLE: begin
        if (cpu_req) begin
          addr_d = cpu_addr;
          if (hit_home) begin
            done_d  = 1'b1;
            hit_d   = 1'b1;
            rdata_d = home_data;
          end else if (early_miss) begin
            phase_d = CA_FILL;
            early_d = 1'b1;
          end else begin
            phase_d = CA_ALT;
            early_d = 1'b0;
          end
        end
      end
      CA_ALT: begin
        if (hit_alt) begin
          done_d    = 1'b1;
          hit_d     = 1'b1;
          rdata_d   = alt_data;
          wr_a_en   = 1'b1;
          wr_a_tag  = alt_tag;
          wr_a_data = alt_data;
          wr_b_en   = 1'b1;
          phase_d   = CA_IDLE;
        end else begin
          phase_d = CA_FILL;
        end
      end
      CA_FILL: begin
        if (mem_valid) begin
          done_d  = 1'b1;
          rdata_d = mem_rdata;
          wr_a_en = 1'b1;
          wr_b_en = !early_q;
          phase_d = CA_IDLE;
        end
      end
      default: phase_d = CA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= CA_IDLE;
      addr_q    <= '0;
      early_q   <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_hit   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      phase_q   <= phase_d;
      addr_q    <= addr_d;
      early_q   <= early_d;
      cpu_done  <= done_d;
      cpu_hit   <= hit_d;
      cpu_rdata <= rdata_d;
    end
  end

  // R2: first-probe hit answers the next cycle
  a_r2_first_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_req && hit_home) |=> (cpu_done && cpu_hit));
  // R6: early miss goes straight to the fetch
  a_r6_early_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_req && !hit_home && early_miss) |=> mem_req);
  // R5: an ordinary first-probe miss spends one cycle on the second probe
  a_r5_second_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_req && !hit_home && !early_miss) |=> (!mem_req && !cpu_done && !cpu_ready));
  // R3: second-probe hit answers and frees the port
  a_r3_second_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == CA_ALT && hit_alt) |=> (cpu_done && cpu_hit && cpu_ready));
  // R9: fetch request is held with a stable address
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
  // R9: returned word is forwarded as a miss response
  a_r9_fill_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (cpu_done && !cpu_hit && cpu_rdata == $past(mem_rdata)));
  // R10: responses only appear with the port idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_ready);
endmodule

// File: rtl/ca_cache.sv
module ca_cache #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W + 1;

  logic [ADDR_W-1:0] probe_addr;
  logic [IDX_W-1:0]  idx_home, idx_alt;
  logic [TAG_W-1:0]  tag_key;
  logic              hit_home, hit_alt, early_miss;
  logic              home_valid, home_rehash, alt_valid;
  logic [TAG_W-1:0]  home_tag, alt_tag;
  logic [DATA_W-1:0] home_data, alt_data;
  logic              wr_a_en, wr_a_valid, wr_a_rehash;
  logic [IDX_W-1:0]  wr_a_idx;
  logic [TAG_W-1:0]  wr_a_tag;
  logic [DATA_W-1:0] wr_a_data;
  logic              wr_b_en, wr_b_valid, wr_b_rehash;
  logic [IDX_W-1:0]  wr_b_idx;
  logic [TAG_W-1:0]  wr_b_tag;
  logic [DATA_W-1:0] wr_b_data;

  ca_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_probe (
    .addr(probe_addr), .home_valid(home_valid), .home_rehash(home_rehash),
    .home_tag(home_tag), .alt_valid(alt_valid), .alt_tag(alt_tag),
    .idx_home(idx_home), .idx_alt(idx_alt), .tag_key(tag_key),
    .hit_home(hit_home), .hit_alt(hit_alt), .early_miss(early_miss)
  );

  ca_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(idx_home), .rd_a_valid(home_valid), .rd_a_rehash(home_rehash),
    .rd_a_tag(home_tag), .rd_a_data(home_data),
    .rd_b_idx(idx_alt), .rd_b_valid(alt_valid), .rd_b_tag(alt_tag),
    .rd_b_data(alt_data),
    .wr_a_en(wr_a_en), .wr_a_idx(wr_a_idx), .wr_a_valid(wr_a_valid),
    .wr_a_rehash(wr_a_rehash), .wr_a_tag(wr_a_tag), .wr_a_data(wr_a_data),
    .wr_b_en(wr_b_en), .wr_b_idx(wr_b_idx), .wr_b_valid(wr_b_valid),
    .wr_b_rehash(wr_b_rehash), .wr_b_tag(wr_b_tag), .wr_b_data(wr_b_data)
  );

  ca_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .probe_addr(probe_addr), .idx_home(idx_home), .idx_alt(idx_alt),
    .tag_key(tag_key), .hit_home(hit_home), .hit_alt(hit_alt),
    .early_miss(early_miss), .home_valid(home_valid), .home_tag(home_tag),
    .home_data(home_data), .alt_tag(alt_tag), .alt_data(alt_data),
    .wr_a_en(wr_a_en), .wr_a_idx(wr_a_idx), .wr_a_valid(wr_a_valid),
    .wr_a_rehash(wr_a_rehash), .wr_a_tag(wr_a_tag), .wr_a_data(wr_a_data),
    .wr_b_en(wr_b_en), .wr_b_idx(wr_b_idx), .wr_b_valid(wr_b_valid),
    .wr_b_rehash(wr_b_rehash), .wr_b_tag(wr_b_tag), .wr_b_data(wr_b_data),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  // R11: an invalid home line is never reported as a first hit
  a_r11_invalid_home: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_req && !home_valid) |=> !cpu_done);
endmodule

// File: tb/ca_cache_test.sv
module ca_cache_test;
  localparam int AW = 12;
  localparam int IW = 3;
  localparam int DW = 16;
  localparam int NL = 1 << IW;
  localparam int HALF = NL / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_ready, cpu_done, cpu_hit;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int n_chk = 0;
  int n_err = 0;

  logic [AW-1:0] m_addr [NL];
  bit            m_v    [NL];
  bit            m_rh   [NL];

  always #2 clk = ~clk;

  ca_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = DW'(a) * 16'd40503;
    return w ^ 16'h3C3C;
  endfunction

  function automatic int home_of(input logic [AW-1:0] a);
    return int'(a) % NL;
  endfunction

  function automatic int alt_of(input logic [AW-1:0] a);
    return (int'(a) % NL) ^ HALF;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory responder: random 0..3 cycle delay
  int wait_cnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      mem_valid = 1'b0;
      if (mem_req) begin
        if (wait_cnt == 0) begin
          mem_valid = 1'b1;
          mem_rdata = mem_word(mem_addr);
          wait_cnt = int'($urandom % 4);
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  // kind: 1 first hit, 2 second hit, 3 early miss, 4 full miss
  task automatic do_read(input logic [AW-1:0] a, input string ctx);
    int h, t, kind, cyc, seen;
    string kt;
    h = home_of(a);
    t = alt_of(a);
    if (m_v[h] && m_addr[h] == a) kind = 1;
    else if (m_v[h] && m_rh[h]) kind = 3;
    else if (m_v[t] && m_addr[t] == a) kind = 2;
    else kind = 4;
    kt = (kind == 1) ? "R2" : (kind == 2) ? "R3" : (kind == 3) ? "R6" : "R5";
    check("R10", {ctx, " ready before request"}, cpu_ready, 1);
    cpu_req = 1'b1;
    cpu_addr = a;
    @(posedge clk);
    @(negedge clk);
    cyc = 1;
    seen = -1;
    if (!cpu_done) begin
      cpu_addr = ~a;  // stray request while busy must be ignored
    end else begin
      cpu_req = 1'b0;
    end
    while (!cpu_done && cyc < 40) begin
      check("R10", {ctx, " ready low while busy"}, cpu_ready, 0);
      if (mem_req && seen < 0) begin
        seen = cyc;
        check("R9", {ctx, " fetch address"}, mem_addr, a);
      end
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0;
      cyc++;
    end
    check(kt, {ctx, " response seen"}, cpu_done, 1);
    check(kt, {ctx, " hit flag"}, cpu_hit, (kind <= 2) ? 1 : 0);
    check(kt, {ctx, " data"}, cpu_rdata, mem_word(a));
    if (kind <= 2) check(kt, {ctx, " hit latency"}, cyc, kind);
    else check(kt, {ctx, " fetch start cycle"}, seen, (kind == 3) ? 1 : 2);
    if (kind == 2 || kind == 4) begin
      m_addr[t] = m_addr[h];
      m_v[t]    = m_v[h];
      m_rh[t]   = 1'b1;
    end
    if (kind != 1) begin
      m_addr[h] = a;
      m_v[h]    = 1'b1;
      m_rh[h]   = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [AW-1:0] a_x, b_x, c_x, d_x;
    void'($urandom(32'd7341));
    for (int i = 0; i < NL; i++) begin
      m_v[i] = 1'b0;
      m_rh[i] = 1'b0;
      m_addr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", cpu_ready, 1);
    check("R1", "done after reset", cpu_done, 0);
    check("R1", "mem_req after reset", mem_req, 0);

    a_x = 12'h0A2;  // home 2, alt 6
    b_x = 12'h1B2;  // home 2
    c_x = 12'h0C6;  // home 6
    d_x = 12'h2D2;  // home 2
    do_read(a_x, "R1 R11 cold miss");
    do_read(a_x, "first hit");
    do_read(b_x, "R7 evict to alt");
    do_read(a_x, "R7 moved block second hit");
    do_read(a_x, "R4 after swap");
    do_read(b_x, "R4 displaced block");
    do_read(c_x, "R8 early miss");
    do_read(b_x, "R8 alt slot kept");
    do_read(d_x, "R7 full miss discards alt");
    do_read(c_x, "R7 discarded block misses");

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] r;
      r = AW'(12'h300 | (($urandom % 4) << IW) | ($urandom % NL));
      do_read(r, "random");
    end
    finish_run();
  end
endmodule